// File: doc/BRIEF.md
# Paged memory command controller

This block serves read and write commands for a small non-volatile style memory of 32-bit pages kept in a register array. A host presents an operation code, a page number and a 16-byte write-data bus for one cycle. A read answers with sixteen bytes streamed one per cycle, taken from four consecutive pages. A write answers with a single acknowledge or negative-acknowledge pulse.

The block enforces the storage rules itself. The identity pages loaded at reset cannot be overwritten. One page only accumulates set bits. One page holds a 16-bit counter that can never move downward. Reads wrap from the last decoded page back to page 0. The compatibility write form carries sixteen bytes but only the first four are stored.

Top module: `pgmem_ctrl`

## Requirements
- R1: While and after reset, `busy`, `rd_valid`, `rd_last` and `resp_valid` are low. Pages 0 and 1 and byte 0 of page 2 hold the identity image, and every other page is zero. Page 0 holds the serial bytes SN0, SN1, SN2 and the check byte 88h^SN0^SN1^SN2. Page 1 holds SN3 to SN6. Byte 0 of page 2 is SN3^SN4^SN5^SN6. Serial byte k is bits [8k+7:8k] of `UID_VALUE`.
- R2: Byte k of a page is bits [8k+7:8k]. A read (op 0) of page P, where P is at most 43, streams 16 bytes: pages P, P+1, P+2 and P+3, each page byte 0 first. `rd_valid` is high for 16 consecutive cycles, starting the cycle after the command is taken. `rd_last`, `resp_valid` and `resp_ack`=1 are all high with the 16th byte, and `busy` is high from the first cycle until then.
- R3: The page sequence of a read wraps after page 43 to page 0, so a read of 43 returns 43, 0, 1, 2.
- R4: A read of a page above 43 gives `resp_valid` with `resp_ack`=0 in the next cycle and no `rd_valid`.
- R5: A write (op 1) to pages 4 to 47, other than page 41, stores `cmd_wdata[31:0]` and acknowledges in the next cycle.
- R6: A compatibility write (op 2) behaves as op 1 for bytes 0 to 3. Bytes 4 to 15 of `cmd_wdata` change nothing.
- R7: Writes to pages 0 and 1 are refused (`resp_ack`=0) with memory unchanged. A write to page 2 stores bytes 1 to 3, keeps byte 0 and acknowledges.
- R8: A write to page 3 stores the OR of old and new data and acknowledges, so a set bit never clears.
- R9: Page 41 bits [15:0] are a counter. A write whose bits [15:0] are not below the current value stores them, keeps bytes 2 and 3 at zero and acknowledges. A lower value is refused with the page unchanged.
- R10: A write to a page of 48 or above, or any command with op 3, is refused in the next cycle with memory unchanged.
- R11: A command presented while `busy` is high is ignored: it gives no response and changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read, 1 write, 2 compatibility write, 3 reserved |
| cmd_page | input | 8 | Page number |
| cmd_wdata | input | 128 | Write bytes, byte k at bits [8k+7:8k] |
| busy | output | 1 | Read stream in progress, commands ignored |
| rd_byte | output | 8 | Streamed read byte |
| rd_valid | output | 1 | `rd_byte` valid |
| rd_last | output | 1 | Final byte of a read |
| resp_valid | output | 1 | Result pulse |
| resp_ack | output | 1 | 1 acknowledge, 0 refusal, valid with `resp_valid` |

## Verification
The bench builds the block at its default size: 48 pages, reads decoded up to page 43, and the identity, one-time and counter pages at 0 to 2, 3 and 41. At that size every start page from 0 to 63 can be read, and every page from 0 to 49 can be written once with both write forms. This covers every wrap offset, every protection class and both sides of the decode and storage limits. Counter writes probe the value just below, equal to and above the stored count.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_CWRITE = 2'd2,
    OP_RSVD   = 2'd3
  } pg_op_e;

  localparam logic [7:0] CASCADE_TAG = 8'h88;
endpackage

// File: rtl/pgmem_array.sv
module pgmem_array #(
  parameter int unsigned   NUM_PAGES = 48,
  parameter int unsigned   WORD_W    = 32,
  parameter int unsigned   PAGE_W    = $clog2(NUM_PAGES),
  parameter int unsigned   UID_PAGES = 2,
  parameter int unsigned   OTP_PAGE  = 3,
  parameter int unsigned   CNT_PAGE  = 41,
  parameter int unsigned   CNT_W     = 16,
  parameter logic [55:0]   UID_VALUE = 56'h66_55_44_33_22_11_04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PAGE_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  import pgmem_pkg::*;

  localparam logic [7:0] CHK_LO = CASCADE_TAG ^ UID_VALUE[7:0] ^ UID_VALUE[15:8] ^ UID_VALUE[23:16];
  localparam logic [7:0] CHK_HI = UID_VALUE[31:24] ^ UID_VALUE[39:32] ^ UID_VALUE[47:40] ^ UID_VALUE[55:48];
  localparam logic [WORD_W-1:0] BOOT_P0 = WORD_W'({CHK_LO, UID_VALUE[23:0]});
  localparam logic [WORD_W-1:0] BOOT_P1 = WORD_W'(UID_VALUE[55:24]);
  localparam logic [WORD_W-1:0] BOOT_P2 = WORD_W'(CHK_HI);

  logic [WORD_W-1:0] mem [NUM_PAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAGES; i++) mem[i] <= '0;
      mem[0]         <= BOOT_P0;
      mem[1]         <= BOOT_P1;
      mem[UID_PAGES] <= BOOT_P2;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R7: identity pages never change after reset
  a_r7_identity_fixed: assert property (@(posedge clk) disable iff (rst)
    $stable(mem[0]) && $stable(mem[1]) && $stable(mem[UID_PAGES][7:0]));
  // R8: one-time page never loses a set bit
  a_r8_otp_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(mem[OTP_PAGE]) & ~mem[OTP_PAGE]) == '0));
  // R9: counter value never decreases
  a_r9_cnt_monotone: assert property (@(posedge clk) disable iff (rst)
    mem[CNT_PAGE][CNT_W-1:0] >= $past(mem[CNT_PAGE][CNT_W-1:0]));
endmodule

// File: rtl/pgmem_wpolicy.sv
module pgmem_wpolicy #(
  parameter int unsigned WORD_W         = 32,
  parameter int unsigned PAGE_W         = 6,
  parameter int unsigned UID_PAGES      = 2,
  parameter int unsigned UID_TAIL_BYTES = 1,
  parameter int unsigned OTP_PAGE       = 3,
  parameter int unsigned CNT_PAGE       = 41,
  parameter int unsigned CNT_W          = 16
) (
  input  logic              wr_req,
  input  logic              in_range,
  input  logic [PAGE_W-1:0] page,
  input  logic [WORD_W-1:0] new_word,
  input  logic [WORD_W-1:0] old_word,
  output logic              ok,
  output logic [WORD_W-1:0] store_word
);
  localparam logic [WORD_W-1:0] TAIL_MASK = (WORD_W'(1) << (8 * UID_TAIL_BYTES)) - WORD_W'(1);
  localparam logic [WORD_W-1:0] CNT_MASK  = (WORD_W'(1) << CNT_W) - WORD_W'(1);

  logic cnt_up;
  assign cnt_up = new_word[CNT_W-1:0] >= old_word[CNT_W-1:0];

  always_comb begin
    ok         = 1'b0;
    store_word = old_word;
    if (wr_req && in_range) begin
      if (page < PAGE_W'(UID_PAGES)) begin
        ok = 1'b0;
      end else if (page == PAGE_W'(UID_PAGES)) begin
        ok         = 1'b1;
        store_word = (new_word & ~TAIL_MASK) | (old_word & TAIL_MASK);
      end else if (page == PAGE_W'(OTP_PAGE)) begin
        ok         = 1'b1;
        store_word = old_word | new_word;
      end else if (page == PAGE_W'(CNT_PAGE)) begin
        ok         = cnt_up;
        store_word = (old_word & ~CNT_MASK) | (new_word & CNT_MASK);
      end else begin
        ok         = 1'b1;
        store_word = new_word;
      end
    end
  end
endmodule

// File: rtl/pgmem_rdstream.sv
module pgmem_rdstream #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PAGE_W     = 6,
  parameter int unsigned DEC_LAST   = 43,
  parameter int unsigned READ_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PAGE_W-1:0] base_page,
  input  logic [WORD_W-1:0] rdata,
  output logic [PAGE_W-1:0] raddr,
  output logic              active,
  output logic              done,
  output logic [7:0]        rd_byte,
  output logic              rd_valid,
  output logic              rd_last
);
  localparam int unsigned BPW    = WORD_W / 8;
  localparam int unsigned NBYTES = BPW * READ_WORDS;
  localparam int unsigned IDX_W  = $clog2(NBYTES);
  localparam int unsigned BSEL_W = $clog2(BPW);

  logic [IDX_W-1:0]  idx;
  logic [PAGE_W-1:0] base_q;
  logic [PAGE_W:0]   sum;
  logic [BSEL_W-1:0] bsel;

  assign sum  = {1'b0, base_q} + (PAGE_W+1)'(idx >> BSEL_W);
  assign raddr = (sum > (PAGE_W+1)'(DEC_LAST)) ? PAGE_W'(sum - (PAGE_W+1)'(DEC_LAST + 1))
                                                : PAGE_W'(sum);
  assign bsel = idx[BSEL_W-1:0];
  assign done = active && (idx == IDX_W'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      idx      <= '0;
      base_q   <= '0;
      rd_byte  <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      if (start) begin
        active <= 1'b1;
        base_q <= base_page;
        idx    <= '0;
      end else if (active) begin
        rd_byte  <= rdata[8*bsel +: 8];
        rd_valid <= 1'b1;
        rd_last  <= done;
        idx      <= idx + 1'b1;
        if (done) active <= 1'b0;
      end
    end
  end

  // R2: last byte flag only accompanies a valid byte that follows another
  a_r2_last_in_stream: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid && $past(rd_valid));
endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl #(
  parameter int unsigned NUM_PAGES  = 48,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned DEC_LAST   = 43,
  parameter int unsigned READ_WORDS = 4,
  parameter int unsigned UID_PAGES  = 2,
  parameter int unsigned OTP_PAGE   = 3,
  parameter int unsigned CNT_PAGE   = 41,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CMD_BYTES  = 16,
  parameter logic [55:0] UID_VALUE  = 56'h66_55_44_33_22_11_04
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [ADDR_W-1:0]      cmd_page,
  input  logic [8*CMD_BYTES-1:0] cmd_wdata,
  output logic                   busy,
  output logic [7:0]             rd_byte,
  output logic                   rd_valid,
  output logic                   rd_last,
  output logic                   resp_valid,
  output logic                   resp_ack
);
  import pgmem_pkg::*;

  localparam int unsigned PAGE_W = $clog2(NUM_PAGES);

  logic              accept, is_rd, is_wr, rd_ok, wr_in_range, wr_ok, start;
  logic              s_active, s_done;
  logic [PAGE_W-1:0] page_idx, s_raddr, arr_raddr;
  logic [WORD_W-1:0] arr_rdata, store_word;
  wire               unused_tail = ^cmd_wdata[8*CMD_BYTES-1:WORD_W];

  assign busy        = s_active;
  assign accept      = cmd_valid && !s_active;
  assign is_rd       = cmd_op == OP_READ;
  assign is_wr       = (cmd_op == OP_WRITE) || (cmd_op == OP_CWRITE);
  assign rd_ok       = cmd_page <= ADDR_W'(DEC_LAST);
  assign wr_in_range = cmd_page < ADDR_W'(NUM_PAGES);
  assign page_idx    = wr_in_range ? PAGE_W'(cmd_page) : '0;
  assign arr_raddr   = s_active ? s_raddr : page_idx;
  assign start       = accept && is_rd && rd_ok;

  pgmem_array #(
    .NUM_PAGES(NUM_PAGES), .WORD_W(WORD_W), .PAGE_W(PAGE_W), .UID_PAGES(UID_PAGES),
    .OTP_PAGE(OTP_PAGE), .CNT_PAGE(CNT_PAGE), .CNT_W(CNT_W), .UID_VALUE(UID_VALUE)
  ) u_array (
    .clk(clk), .rst(rst), .we(accept && is_wr && wr_ok), .waddr(page_idx),
    .wdata(store_word), .raddr(arr_raddr), .rdata(arr_rdata)
  );

  pgmem_wpolicy #(
    .WORD_W(WORD_W), .PAGE_W(PAGE_W), .UID_PAGES(UID_PAGES), .UID_TAIL_BYTES(1),
    .OTP_PAGE(OTP_PAGE), .CNT_PAGE(CNT_PAGE), .CNT_W(CNT_W)
  ) u_policy (
    .wr_req(accept && is_wr), .in_range(wr_in_range), .page(page_idx),
    .new_word(cmd_wdata[WORD_W-1:0]), .old_word(arr_rdata),
    .ok(wr_ok), .store_word(store_word)
  );

  pgmem_rdstream #(
    .WORD_W(WORD_W), .PAGE_W(PAGE_W), .DEC_LAST(DEC_LAST), .READ_WORDS(READ_WORDS)
  ) u_stream (
    .clk(clk), .rst(rst), .start(start), .base_page(page_idx), .rdata(arr_rdata),
    .raddr(s_raddr), .active(s_active), .done(s_done),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .rd_last(rd_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        if (is_rd) begin
          if (!rd_ok) begin
            resp_valid <= 1'b1;
            resp_ack   <= 1'b0;
          end
        end else begin
          resp_valid <= 1'b1;
          resp_ack   <= is_wr && wr_ok;
        end
      end else if (s_done) begin
        resp_valid <= 1'b1;
        resp_ack   <= 1'b1;
      end
    end
  end

  // R4: undecoded read is refused at once without data
  a_r4_read_nak: assert property (@(posedge clk) disable iff (rst)
    accept && is_rd && !rd_ok |=> resp_valid && !resp_ack && !rd_valid);
  // R2: a decoded read enters the stream without an early response
  a_r2_read_starts: assert property (@(posedge clk) disable iff (rst)
    accept && is_rd && rd_ok |=> busy && !resp_valid);
  // R7: identity pages refuse writes
  a_r7_identity_nak: assert property (@(posedge clk) disable iff (rst)
    accept && is_wr && (cmd_page < ADDR_W'(UID_PAGES)) |=> resp_valid && !resp_ack);
  // R10: out-of-range write or reserved op is refused
  a_r10_refused: assert property (@(posedge clk) disable iff (rst)
    accept && (cmd_op == OP_RSVD || (is_wr && !wr_in_range)) |=> resp_valid && !resp_ack);
  // R11: no response appears while a stream holds the block
  a_r11_quiet_busy: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !busy);
endmodule

// File: tb/tb_pgmem_ctrl.sv
`timescale 1ns/1ps
module tb_pgmem_ctrl;
  localparam logic [55:0] UIDV = 56'h66_55_44_33_22_11_04;
  localparam int NPG  = 48;
  localparam int DECN = 44;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'd0;
  logic [7:0]   cmd_page = 8'd0;
  logic [127:0] cmd_wdata = '0;
  logic         busy, rd_valid, rd_last, resp_valid, resp_ack;
  logic [7:0]   rd_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] m [NPG];

  always #2.5 clk = ~clk;

  pgmem_ctrl #(.NUM_PAGES(48), .WORD_W(32), .DEC_LAST(43), .READ_WORDS(4), .UID_PAGES(2),
               .OTP_PAGE(3), .CNT_PAGE(41), .CNT_W(16), .ADDR_W(8), .CMD_BYTES(16),
               .UID_VALUE(UIDV)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .cmd_wdata(cmd_wdata), .busy(busy), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .rd_last(rd_last), .resp_valid(resp_valid), .resp_ack(resp_ack));

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_apply(input int op, input int page, input logic [31:0] w);
    if (op == 3 || op == 0 || page >= NPG || page < 2) return 1'b0;
    if (page == 2) begin m[2] = {w[31:8], m[2][7:0]}; return 1'b1; end
    if (page == 3) begin m[3] = m[3] | w; return 1'b1; end
    if (page == 41) begin
      if (w[15:0] >= m[41][15:0]) begin m[41][15:0] = w[15:0]; return 1'b1; end
      return 1'b0;
    end
    m[page] = w;
    return 1'b1;
  endfunction

  task automatic do_cmd(input logic [1:0] op, input int page, input logic [127:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_page = page[7:0]; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr_check(input logic [1:0] op, input int page, input logic [127:0] wd, input string tag);
    bit exp_ack;
    exp_ack = model_apply(op, page, wd[31:0]);
    do_cmd(op, page, wd);
    chk(resp_valid && (resp_ack == exp_ack) && !busy, tag,
        {30'd0, resp_valid, resp_ack}, {30'd0, 1'b1, exp_ack});
  endtask

  task automatic rd_check(input int page, input string tag);
    int bad;
    logic [7:0] got_b, exp_b;
    do_cmd(2'd0, page, '0);
    if (page >= DECN) begin
      chk(resp_valid && !resp_ack && !rd_valid, tag, {29'd0, resp_valid, resp_ack, rd_valid}, 32'h4);
      @(negedge clk);
      chk(!rd_valid && !busy && !resp_valid, tag, {29'd0, rd_valid, busy, resp_valid}, 32'h0);
      return;
    end
    bad = 0; got_b = '0; exp_b = '0;
    if (!busy || rd_valid || resp_valid) bad++;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] e;
      @(negedge clk);
      e = m[(page + k / 4) % DECN][8 * (k % 4) +: 8];
      if (!rd_valid || rd_byte != e) begin
        if (bad == 0) begin got_b = rd_byte; exp_b = e; end
        bad++;
      end
      if (k == 15 && !(rd_last && resp_valid && resp_ack && !busy)) bad++;
      if (k < 15 && (rd_last || resp_valid || !busy)) bad++;
    end
    chk(bad == 0, tag, {24'd0, got_b}, {24'd0, exp_b});
  endtask

  function automatic logic [31:0] pat(input int p);
    logic [7:0] b;
    b = p[7:0];
    return {b * 8'd7 + 8'd1, b ^ 8'h5A, b + 8'h90, ~b};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int resp_cnt;
    for (int i = 0; i < NPG; i++) m[i] = '0;
    m[0] = {8'h88 ^ UIDV[7:0] ^ UIDV[15:8] ^ UIDV[23:16], UIDV[23:0]};
    m[1] = UIDV[55:24];
    m[2] = {24'd0, UIDV[31:24] ^ UIDV[39:32] ^ UIDV[47:40] ^ UIDV[55:48]};

    repeat (4) @(negedge clk);
    chk(!busy && !rd_valid && !rd_last && !resp_valid, "R1 outputs in reset",
        {28'd0, busy, rd_valid, rd_last, resp_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_valid && !rd_last && !resp_valid, "R1 outputs after reset",
        {28'd0, busy, rd_valid, rd_last, resp_valid}, 32'h0);

    // R1 R2 R3: initial image through every start page
    for (int p = 0; p < DECN; p++) rd_check(p, p >= DECN - 3 ? "R3 wrap initial" : "R1 R2 initial image");
    // R4: undecoded reads
    for (int p = DECN; p < 64; p++) rd_check(p, "R4 undecoded read");
    rd_check(200, "R4 undecoded read 200");
    rd_check(255, "R4 undecoded read 255");

    // R10: reserved op and out-of-range writes
    wr_check(2'd3, 10, {96'd0, 32'h1111_2222}, "R10 reserved op");
    wr_check(2'd1, 48, {96'd0, 32'h3333_4444}, "R10 write page 48");
    wr_check(2'd2, 49, {96'd0, 32'h5555_6666}, "R10 write page 49");
    wr_check(2'd1, 255, {96'd0, 32'h7777_8888}, "R10 write page 255");

    // Write sweep: even pages plain write, odd pages compatibility write with junk tail
    for (int p = 0; p < NPG; p++) begin
      logic [31:0] w;
      string tg;
      w = (p == 41) ? 32'hABCD_1234 : pat(p);
      if (p < 3) tg = "R7 protected pages";
      else if (p == 3) tg = "R8 one-time page";
      else if (p == 41) tg = "R9 counter first write";
      else if (p % 2 == 1) tg = "R6 compatibility write";
      else tg = "R5 plain write";
      if (p % 2 == 1) wr_check(2'd2, p, {~{32'd0}, 32'hF00D_BEEF ^ {p[7:0], 24'd0}, 32'h1357_9BDF, w}, tg);
      else wr_check(2'd1, p, {96'd0, w}, tg);
    end
    for (int p = 0; p < DECN; p++) rd_check(p, p >= DECN - 3 ? "R3 wrap after writes" : "R5 R6 R7 readback");

    // R8: bits only accumulate
    wr_check(2'd1, 3, {96'd0, 32'h0000_0000}, "R8 zero write keeps bits");
    wr_check(2'd2, 3, {96'hFFFF, 32'h8000_0001}, "R8 OR merge");
    rd_check(3, "R8 one-time readback");

    // R9: counter monotonic
    wr_check(2'd1, 41, {96'd0, 32'h0000_1233}, "R9 lower refused");
    wr_check(2'd1, 41, {96'd0, 32'h0000_1234}, "R9 equal accepted");
    wr_check(2'd1, 41, {96'd0, 32'hFFFF_8000}, "R9 higher accepted");
    wr_check(2'd1, 41, {96'd0, 32'h0000_7FFF}, "R9 lower refused again");
    rd_check(40, "R9 counter readback");

    // R11: command while streaming is ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_page = 8'd5; cmd_wdata = '0;
    @(negedge clk);
    cmd_op = 2'd1; cmd_page = 8'd6; cmd_wdata = {96'd0, 32'hCAFE_F00D};
    resp_cnt = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (c == 0) cmd_valid = 1'b0;
      if (resp_valid) resp_cnt++;
    end
    chk(resp_cnt == 1, "R11 single response during stream", resp_cnt, 32'd1);
    rd_check(6, "R11 page unchanged");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule